// File: doc/BRIEF.md
# Low-Frequency Backup Real-Time Counter

This block is a wide up-counter that keeps time from one of three slow oscillators. The oscillators are outside the block. Each one arrives as a one-cycle strobe on the system clock. A two-bit selector picks the source, or picks none. A power-of-two prescaler then thins the chosen strobe stream into counter ticks. The slowest oscillator is the exception: it runs at its full 2 kHz rate only when the prescaler exponent is zero, and at half rate for any other exponent.

A single compare register drives a sticky match flag. Optionally the compare value also becomes the top of the count, so the counter returns to zero after reaching it. A low-power compare mode ignores a programmable number of low counter bits when matching. Wrapping from all-ones sets a sticky overflow flag. Both flags clear on a write-one pulse.

A hold bit keeps the counter and prescaler at zero, so toggling it restarts time from zero. A debug-halt input freezes the count unless the debug-run bit allows counting on. The block also reports the effective tick rate in hertz.

Top module: `lf_backup_rtc`

## Requirements
- R1: While `cfg_hold` is 1, `count` is 0 from the next cycle on, the prescaler is cleared and no flag is set. After `cfg_hold` returns to 0, counting resumes from 0.
- R2: With `cfg_clksel` = 0 (no source), `count` does not change for any strobe, and `rate_hz` is 0.
- R3: With `cfg_clksel` = 2 (low RC, strobe `lrc_pulse`) or 3 (crystal, strobe `lxo_pulse`), the counter advances once per 2^`cfg_presc` strobes of the selected source. Strobes of the other sources have no effect. `rate_hz` equals 32768 >> `cfg_presc`.
- R4: With `cfg_clksel` = 1 (ultra-low RC, strobe `ulf_pulse`), every strobe advances the counter when `cfg_presc` = 0, and `rate_hz` is 2000. For any other `cfg_presc`, every second strobe advances the counter and `rate_hz` is 1000.
- R5: A tick that leaves `count` equal to `cmp_value` sets `cmp_flag` one clock later. The flag stays set until a cycle with `flag_clr[0]` = 1.
- R6: With `cfg_cmp_top` = 1, a tick taken while `count` equals `cmp_value` returns `count` to 0.
- R7: A tick taken while `count` is all ones returns it to 0 and sets `ovf_flag`. The flag stays set until a cycle with `flag_clr[1]` = 1.
- R8: With `cfg_lp_en` = 1 and source 2 or 3, the compare ignores the lowest `cfg_lp_skip` bits of both `count` and `cmp_value`, and a skip value of 7 acts as 6. With source 1, no bits are ignored.
- R9: With `dbg_halt` = 1 and `cfg_dbg_run` = 0, strobes do not advance `count`. With `cfg_dbg_run` = 1, `dbg_halt` has no effect.
- R10: When a flag's set event and its clear bit fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ulf_pulse | input | 1 | Ultra-low RC strobe at a 2 kHz base rate |
| lrc_pulse | input | 1 | Low RC strobe at 32768 Hz |
| lxo_pulse | input | 1 | Crystal strobe at 32768 Hz |
| cfg_clksel | input | 2 | Source: 0 none, 1 ultra-low RC, 2 low RC, 3 crystal |
| cfg_presc | input | 3 | Prescaler exponent |
| cfg_hold | input | 1 | Hold the counter and prescaler at zero |
| cfg_cmp_top | input | 1 | Wrap the counter at `cmp_value` |
| cfg_dbg_run | input | 1 | Keep counting while in debug halt |
| cfg_lp_en | input | 1 | Enable low-power compare masking |
| cfg_lp_skip | input | 3 | Number of low bits ignored in the compare |
| cmp_value | input | CNT_W | Compare value |
| dbg_halt | input | 1 | Debug halt request |
| flag_clr | input | 2 | Write-one clear: bit 0 compare flag, bit 1 overflow flag |
| count | output | CNT_W | Counter value |
| cmp_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| rate_hz | output | 16 | Effective tick rate in Hz |

## Verification
The two functions that can meet in one cycle are a flag's set event and its write-one clear. The bench provokes this in low-power compare mode. There, several consecutive counts all match the masked compare value. With the flag already set, the bench drives a source strobe and `flag_clr[0]` together on the same cycle. It then requires the flag to read 1 afterwards, and a clear with no strobe to read 0. A checker property requires every match event to leave the flag set on the following cycle, whatever the clear input does.

// File: rtl/lfrtc_pkg.sv
package lfrtc_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ULF  = 2'd1,
    SRC_LRC  = 2'd2,
    SRC_LXO  = 2'd3
  } src_e;

  localparam int EXP_W   = 3;
  localparam int PRE_W   = (1 << EXP_W) - 1;
  localparam int RATE_W  = 16;
  localparam int LF_HZ   = 32768;
  localparam int ULF_HI  = 2000;
  localparam int ULF_LO  = 1000;
  localparam int SKIP_MX = 6;

  // Prescaler exponent actually applied for a given source
  function automatic logic [EXP_W-1:0] eff_exp(input logic [1:0] sel,
                                               input logic [EXP_W-1:0] e);
    if (sel == SRC_ULF) return (e == '0) ? EXP_W'(0) : EXP_W'(1);
    return e;
  endfunction

  // Reported tick rate in hertz
  function automatic logic [RATE_W-1:0] tick_rate(input logic [1:0] sel,
                                                  input logic [EXP_W-1:0] e);
    logic [RATE_W:0] base;
    base = (RATE_W+1)'(LF_HZ);
    case (sel)
      SRC_ULF:          return (e == '0) ? RATE_W'(ULF_HI) : RATE_W'(ULF_LO);
      SRC_LRC, SRC_LXO: return RATE_W'(base >> e);
      default:          return '0;
    endcase
  endfunction

  // Number of counter bits ignored by the compare
  function automatic logic [EXP_W-1:0] eff_skip(input logic [1:0] sel,
                                                input logic lp_en,
                                                input logic [EXP_W-1:0] s);
    if (!lp_en) return '0;
    if (sel != SRC_LRC && sel != SRC_LXO) return '0;
    if (s > EXP_W'(SKIP_MX)) return EXP_W'(SKIP_MX);
    return s;
  endfunction

endpackage

// File: rtl/lfrtc_tick_gen.sv
module lfrtc_tick_gen
  import lfrtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic [EXP_W-1:0] presc,
  input  logic             ulf_pulse,
  input  logic             lrc_pulse,
  input  logic             lxo_pulse,
  input  logic             hold,
  input  logic             run_ok,
  output logic             tick
);

  logic             src_pulse;
  logic             step;
  logic [EXP_W-1:0] exp_now;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_mask;

  always_comb begin
    case (sel)
      SRC_ULF: src_pulse = ulf_pulse;
      SRC_LRC: src_pulse = lrc_pulse;
      SRC_LXO: src_pulse = lxo_pulse;
      default: src_pulse = 1'b0;
    endcase
  end

  assign exp_now = eff_exp(sel, presc);
  assign step    = src_pulse && run_ok && !hold;

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign pre_mask[i] = (EXP_W'(i) < exp_now);
  end

  assign tick = step && ((pre_cnt & pre_mask) == pre_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_cnt <= '0;
    else if (hold) pre_cnt <= '0;
    else if (step) pre_cnt <= pre_cnt + 1'b1;
  end

endmodule

// File: rtl/lfrtc_counter.sv
module lfrtc_counter
  import lfrtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tick,
  input  logic             cmp_top,
  input  logic [CNT_W-1:0] cmp_value,
  input  logic [EXP_W-1:0] skip,
  output logic [CNT_W-1:0] count,
  output logic             cmp_evt,
  output logic             ovf_evt,
  output logic             top_evt
);

  logic [CNT_W-1:0] ign;
  logic [CNT_W-1:0] count_nx;
  logic             at_top;
  logic             at_max;

  for (genvar i = 0; i < CNT_W; i++) begin : g_ign
    if (i < PRE_W) begin : g_low
      assign ign[i] = (EXP_W'(i) < skip);
    end else begin : g_high
      assign ign[i] = 1'b0;
    end
  end

  assign at_top   = cmp_top && (count == cmp_value);
  assign at_max   = &count;
  assign count_nx = (at_top || at_max) ? '0 : count + 1'b1;
  assign top_evt  = tick && at_top;
  assign ovf_evt  = tick && at_max;
  assign cmp_evt  = tick && ((count_nx & ~ign) == (cmp_value & ~ign));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (hold) count <= '0;
    else if (tick) count <= count_nx;
  end

endmodule

// File: rtl/lfrtc_flags.sv
module lfrtc_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] flag
);

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[g] <= 1'b0;
      else if (set[g]) flag[g] <= 1'b1;
      else if (clr[g]) flag[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/lf_backup_rtc.sv
module lf_backup_rtc
  import lfrtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ulf_pulse,
  input  logic             lrc_pulse,
  input  logic             lxo_pulse,
  input  logic [1:0]       cfg_clksel,
  input  logic [2:0]       cfg_presc,
  input  logic             cfg_hold,
  input  logic             cfg_cmp_top,
  input  logic             cfg_dbg_run,
  input  logic             cfg_lp_en,
  input  logic [2:0]       cfg_lp_skip,
  input  logic [CNT_W-1:0] cmp_value,
  input  logic             dbg_halt,
  input  logic [1:0]       flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             cmp_flag,
  output logic             ovf_flag,
  output logic [15:0]      rate_hz
);

  localparam int NFLAG = 2;

  logic             run_ok;
  logic             tick;
  logic             cmp_evt;
  logic             ovf_evt;
  logic             top_evt;
  logic [EXP_W-1:0] skip_now;
  logic [NFLAG-1:0] flag_q;

  assign run_ok   = cfg_dbg_run || !dbg_halt;
  assign skip_now = eff_skip(cfg_clksel, cfg_lp_en, cfg_lp_skip);
  assign rate_hz  = tick_rate(cfg_clksel, cfg_presc);

  lfrtc_tick_gen u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (cfg_clksel),
    .presc     (cfg_presc),
    .ulf_pulse (ulf_pulse),
    .lrc_pulse (lrc_pulse),
    .lxo_pulse (lxo_pulse),
    .hold      (cfg_hold),
    .run_ok    (run_ok),
    .tick      (tick)
  );

  lfrtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (cfg_hold),
    .tick      (tick),
    .cmp_top   (cfg_cmp_top),
    .cmp_value (cmp_value),
    .skip      (skip_now),
    .count     (count),
    .cmp_evt   (cmp_evt),
    .ovf_evt   (ovf_evt),
    .top_evt   (top_evt)
  );

  lfrtc_flags #(.NFLAG(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   ({ovf_evt, cmp_evt}),
    .clr   (flag_clr),
    .flag  (flag_q)
  );

  assign cmp_flag = flag_q[0];
  assign ovf_flag = flag_q[1];

endmodule

// File: rtl/lfrtc_chk.sv
module lfrtc_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_clksel,
  input logic             cfg_hold,
  input logic             cfg_dbg_run,
  input logic             dbg_halt,
  input logic [CNT_W-1:0] count,
  input logic             cmp_flag,
  input logic             ovf_flag,
  input logic [15:0]      rate_hz,
  input logic [1:0]       flag_clr,
  input logic             tick,
  input logic             cmp_evt,
  input logic             ovf_evt,
  input logic             top_evt
);

  // R1
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hold |=> (count == '0));

  // R2
  none_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clksel == 2'd0 && !cfg_hold) |=> $stable(count));

  // R2
  none_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clksel == 2'd0) |-> (rate_hz == 16'd0));

  // R5
  cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[0] && !cmp_evt) |=> !cmp_flag);

  // R6
  top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_evt && !cfg_hold) |=> (count == '0));

  // R7
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !cfg_hold) |=> (count == '0 && ovf_flag));

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !cfg_dbg_run && !cfg_hold) |=> $stable(count));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> cmp_flag);

  // R1
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hold |-> !tick);

endmodule

bind lf_backup_rtc lfrtc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_clksel  (cfg_clksel),
  .cfg_hold    (cfg_hold),
  .cfg_dbg_run (cfg_dbg_run),
  .dbg_halt    (dbg_halt),
  .count       (count),
  .cmp_flag    (cmp_flag),
  .ovf_flag    (ovf_flag),
  .rate_hz     (rate_hz),
  .flag_clr    (flag_clr),
  .tick        (tick),
  .cmp_evt     (cmp_evt),
  .ovf_evt     (ovf_evt),
  .top_evt     (top_evt)
);

// File: tb/tb_lf_backup_rtc.sv
module tb_lf_backup_rtc;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ulf_pulse = 0, lrc_pulse = 0, lxo_pulse = 0;
  logic [1:0]   cfg_clksel = 0;
  logic [2:0]   cfg_presc = 0;
  logic         cfg_hold = 0, cfg_cmp_top = 0, cfg_dbg_run = 0, cfg_lp_en = 0;
  logic [2:0]   cfg_lp_skip = 0;
  logic [W-1:0] cmp_value = '1;
  logic         dbg_halt = 0;
  logic [1:0]   flag_clr = 0;
  logic [W-1:0] count;
  logic         cmp_flag, ovf_flag;
  logic [15:0]  rate_hz;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lf_backup_rtc #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .ulf_pulse(ulf_pulse), .lrc_pulse(lrc_pulse),
    .lxo_pulse(lxo_pulse), .cfg_clksel(cfg_clksel), .cfg_presc(cfg_presc),
    .cfg_hold(cfg_hold), .cfg_cmp_top(cfg_cmp_top), .cfg_dbg_run(cfg_dbg_run),
    .cfg_lp_en(cfg_lp_en), .cfg_lp_skip(cfg_lp_skip), .cmp_value(cmp_value),
    .dbg_halt(dbg_halt), .flag_clr(flag_clr), .count(count),
    .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .rate_hz(rate_hz)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // which: 1 ultra-low, 2 low RC, 3 crystal
  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ulf_pulse = (which == 1);
      lrc_pulse = (which == 2);
      lxo_pulse = (which == 3);
      @(negedge clk);
      ulf_pulse = 0; lrc_pulse = 0; lxo_pulse = 0;
    end
  endtask

  task automatic restart();
    @(negedge clk);
    cfg_hold = 1; flag_clr = 2'b11;
    @(negedge clk);
    cfg_hold = 0; flag_clr = 2'b00;
  endtask

  task automatic clear(input logic [1:0] v);
    @(negedge clk); flag_clr = v;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic t_reset();
    check("R1 reset count", count, 0);
    check("R1 reset cmp_flag", cmp_flag, 0);
    check("R1 reset ovf_flag", ovf_flag, 0);
    check("R2 reset rate", rate_hz, 0);
  endtask

  task automatic t_none();
    cfg_clksel = 0; restart();
    pulse(1, 3); pulse(2, 3); pulse(3, 3);
    check("R2 none count", count, 0);
    check("R2 none rate", rate_hz, 0);
  endtask

  task automatic t_lf_presc();
    int exps[3] = '{0, 2, 3};
    foreach (exps[k]) begin
      cfg_clksel = 2; cfg_presc = 3'(exps[k]); restart();
      pulse(2, 3 << exps[k]);
      pulse(3, 5);
      pulse(1, 5);
      check("R3 low RC count", count, 3);
      check("R3 low RC rate", rate_hz, 32768 >> exps[k]);
    end
    cfg_clksel = 3; cfg_presc = 7; restart();
    pulse(3, 127);
    check("R3 crystal before tick", count, 0);
    pulse(3, 1);
    check("R3 crystal /128", count, 1);
    check("R3 crystal rate", rate_hz, 256);
    cfg_hold = 1;
    @(negedge clk);
    check("R1 hold clears", count, 0);
    pulse(3, 128);
    check("R1 hold ignores strobes", count, 0);
    cfg_hold = 0;
    pulse(3, 128);
    check("R1 restart from zero", count, 1);
  endtask

  task automatic t_ulf();
    cfg_clksel = 1; cfg_presc = 0; restart();
    pulse(1, 5);
    check("R4 ulf div1 count", count, 5);
    check("R4 ulf div1 rate", rate_hz, 2000);
    cfg_presc = 3; restart();
    pulse(1, 6);
    check("R4 ulf div8 count", count, 3);
    check("R4 ulf div8 rate", rate_hz, 1000);
  endtask

  task automatic t_cmp();
    cfg_clksel = 2; cfg_presc = 0; cmp_value = 10; restart();
    pulse(2, 9);
    check("R5 before match", cmp_flag, 0);
    pulse(2, 1);
    check("R5 match flag", cmp_flag, 1);
    pulse(2, 3);
    check("R5 sticky", cmp_flag, 1);
    clear(2'b01);
    check("R5 cleared", cmp_flag, 0);
  endtask

  task automatic t_top();
    cfg_clksel = 2; cfg_presc = 0; cfg_cmp_top = 1; cmp_value = 5; restart();
    pulse(2, 5);
    check("R6 at top", count, 5);
    pulse(2, 1);
    check("R6 wrap to zero", count, 0);
    check("R6 no overflow", ovf_flag, 0);
    cfg_cmp_top = 0;
  endtask

  task automatic t_ovf();
    cfg_clksel = 2; cfg_presc = 0; cmp_value = 8'h80; restart();
    pulse(2, 255);
    check("R7 all ones", count, 255);
    check("R7 no flag yet", ovf_flag, 0);
    pulse(2, 1);
    check("R7 wrap", count, 0);
    check("R7 ovf flag", ovf_flag, 1);
    clear(2'b10);
    check("R7 ovf cleared", ovf_flag, 0);
  endtask

  task automatic t_lp();
    cfg_clksel = 2; cfg_presc = 0; cfg_lp_en = 1; cfg_lp_skip = 3;
    cmp_value = 8'h20; restart();
    pulse(2, 31);
    check("R8 below window", cmp_flag, 0);
    pulse(2, 1);
    check("R8 window start", cmp_flag, 1);
    clear(2'b01);
    pulse(2, 1);
    check("R8 masked match 33", cmp_flag, 1);
    cfg_lp_skip = 7; cmp_value = 8'h40; restart();
    pulse(2, 1);
    check("R8 skip7 acts as 6", cmp_flag, 0);
    pulse(2, 62);
    check("R8 skip6 below", cmp_flag, 0);
    pulse(2, 1);
    check("R8 skip6 hit 64", cmp_flag, 1);
    cfg_clksel = 1; cfg_lp_skip = 3; cmp_value = 8'h20; restart();
    pulse(1, 33);
    clear(2'b01);
    pulse(1, 1);
    check("R8 ulf no mask", cmp_flag, 0);
    cfg_lp_en = 0; cfg_lp_skip = 0;
  endtask

  task automatic t_halt();
    cfg_clksel = 2; cfg_presc = 0; restart();
    pulse(2, 4);
    dbg_halt = 1; cfg_dbg_run = 0;
    pulse(2, 4);
    check("R9 frozen", count, 4);
    cfg_dbg_run = 1;
    pulse(2, 4);
    check("R9 debug run", count, 8);
    dbg_halt = 0; cfg_dbg_run = 0;
  endtask

  task automatic t_race();
    cfg_clksel = 2; cfg_presc = 0; cfg_lp_en = 1; cfg_lp_skip = 2;
    cmp_value = 4; restart();
    pulse(2, 4);
    check("R10 flag set", cmp_flag, 1);
    @(negedge clk); lrc_pulse = 1; flag_clr = 2'b01;
    @(negedge clk); lrc_pulse = 0; flag_clr = 2'b00;
    check("R10 count", count, 5);
    check("R10 set wins", cmp_flag, 1);
    clear(2'b01);
    check("R10 plain clear", cmp_flag, 0);
    cfg_lp_en = 0; cfg_lp_skip = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_none();
    t_lf_presc();
    t_ulf();
    t_cmp();
    t_top();
    t_ovf();
    t_lp();
    t_halt();
    t_race();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule